// File: doc/BRIEF.md
# Next-PC and Branch Target Unit

This block works out where a processor with fixed 4-byte instructions goes next. Each issued instruction supplies its own address and decoded fields: a 4-bit flow kind, a 3-bit compare selector, a 16-bit immediate, a 26-bit word index, two register operands, the return-address value and a destination register number. From these the block produces the following program counter. It also produces a request to write a link value (the address of the next sequential instruction) into a register.

The inputs are taken on a rising clock edge while `issue` is high. The results appear on registered outputs after that edge. In cycles where `issue` is low, the next PC holds and no link write is requested. The register file, fetch and exception handling lie outside the block. The parent writes `link_data` into register `link_dst` whenever `link_we` is high.

Top module: `nxpc_unit`

## Requirements
- R1: While the core reset is asserted, and after it, until the first issued instruction, `npc` equals the `RESET_PC` parameter (default 0) and `link_we` is 0.
- R2: Kind 0 (sequential), and every kind code from 9 to 15, gives `npc` = `pc` + 4 modulo 2^32 with no link write.
- R3: Kind 1 (absolute jump) gives `npc` = {`pc`[31:28], `imm26`, 2'b00}.
- R4: Kind 2 (call) gives the same target as R3 and writes `pc` + 4 into register 31.
- R5: Kind 3 (unconditional branch) gives `npc` = `pc` + 4 + sign-extended `imm16`, with bits [1:0] of the offset cleared.
- R6: Kind 4 (conditional branch) takes the R5 target when the condition holds, and otherwise gives `pc` + 4. The condition compares A with B. Selector 0 is A ≥ B signed, 1 is A < B signed, 2 is A ≠ B, 3 is A = B, 4 is A ≥ B unsigned and 5 is A < B unsigned. Selectors 6 and 7 are never taken.
- R7: Kind 5 (return) gives `npc` = `ra_val`. Kind 6 (register jump) gives `npc` = `opnd_a`.
- R8: Kind 7 (register call) gives `npc` = `opnd_a` and writes `pc` + 4 into register 31. The jump uses the operand value presented with the instruction, never the link value written by that same call.
- R9: Kind 8 (read next address) gives `npc` = `pc` + 4 and writes `pc` + 4 into register `dst`. It requests no write when `dst` is 0.
- R10: Kinds 0, 1, 3, 4, 5 and 6 never raise `link_we`.
- R11: A cycle with `issue` low leaves `npc` unchanged and drives `link_we` to 0 on the following edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| issue | input | 1 | Accept the instruction fields on this edge |
| pc | input | 32 | Address of the issued instruction |
| kind | input | 4 | Flow kind code (see R2 to R9) |
| cond | input | 3 | Compare selector for conditional branches |
| imm16 | input | 16 | Branch byte offset |
| imm26 | input | 26 | Absolute jump word index |
| opnd_a | input | 32 | First register operand |
| opnd_b | input | 32 | Second register operand |
| ra_val | input | 32 | Current return-address register value |
| dst | input | 5 | Destination register for kind 8 |
| npc | output | 32 | Registered next program counter |
| link_we | output | 1 | Registered link write request |
| link_dst | output | 5 | Register number for the link write |
| link_data | output | 32 | Value for the link write |

## Verification
Every decision the block makes is latched in a single output stage. A wrong target, a wrong compare or a wrong link decision therefore shows up on `npc` or `link_we` on the very edge after the instruction is issued. It never appears later. Bad hold logic shows up as `npc` drifting, or as `link_we` staying high, in the first idle cycle. The corner cases that expose a faulty comparator or adder are the signed/unsigned split around 0x80000000, negative offsets and address wrap.

// File: rtl/nxpc_pkg.sv
package nxpc_pkg;
  typedef enum logic [3:0] {
    K_SEQ   = 4'd0,
    K_JABS  = 4'd1,
    K_CALL  = 4'd2,
    K_BRU   = 4'd3,
    K_BCOND = 4'd4,
    K_RET   = 4'd5,
    K_JREG  = 4'd6,
    K_CALLR = 4'd7,
    K_NXPC  = 4'd8
  } flow_kind_e;

  typedef enum logic [2:0] {
    C_GES = 3'd0,
    C_LTS = 3'd1,
    C_NE  = 3'd2,
    C_EQ  = 3'd3,
    C_GEU = 3'd4,
    C_LTU = 3'd5
  } cmp_sel_e;
endpackage

// File: rtl/nxpc_cmp.sv
module nxpc_cmp #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] a,
  input  logic [XLEN-1:0] b,
  input  logic [2:0]      sel,
  output logic            take
);
  import nxpc_pkg::*;

  logic eq, lt_s, lt_u;

  assign eq   = (a == b);
  assign lt_s = ($signed(a) < $signed(b));
  assign lt_u = (a < b);

  always_comb begin
    case (sel)
      C_GES:   take = ~lt_s;
      C_LTS:   take = lt_s;
      C_NE:    take = ~eq;
      C_EQ:    take = eq;
      C_GEU:   take = ~lt_u;
      C_LTU:   take = lt_u;
      default: take = 1'b0;
    endcase
  end
endmodule

// File: rtl/nxpc_targets.sv
module nxpc_targets #(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int HI_KEEP = 4,
  localparam int JW     = XLEN - HI_KEEP - 2
) (
  input  logic [XLEN-1:0]  pc,
  input  logic [IMM_W-1:0] imm16,
  input  logic [JW-1:0]    imm26,
  output logic [XLEN-1:0]  seq,
  output logic [XLEN-1:0]  jabs,
  output logic [XLEN-1:0]  bra
);
  localparam logic [XLEN-1:0] STEP = XLEN'(4);
  localparam logic [XLEN-1:0] ALIGN_MASK = ~XLEN'(3);

  logic [XLEN-1:0] off;

  assign seq  = pc + STEP;
  assign jabs = {pc[XLEN-1 -: HI_KEEP], imm26, 2'b00};
  assign off  = {{(XLEN-IMM_W){imm16[IMM_W-1]}}, imm16} & ALIGN_MASK;
  assign bra  = seq + off;
endmodule

// File: rtl/nxpc_route.sv
module nxpc_route #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5,
  parameter int RA_IDX = 31
) (
  input  logic [3:0]        kind,
  input  logic              take,
  input  logic [XLEN-1:0]   seq,
  input  logic [XLEN-1:0]   jabs,
  input  logic [XLEN-1:0]   bra,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [REG_AW-1:0] dst,
  output logic [XLEN-1:0]   npc_d,
  output logic              we_d,
  output logic [REG_AW-1:0] dst_d
);
  import nxpc_pkg::*;

  localparam logic [REG_AW-1:0] RA = REG_AW'(RA_IDX);

  always_comb begin
    npc_d = seq;
    we_d  = 1'b0;
    dst_d = dst;
    case (kind)
      K_JABS:  npc_d = jabs;
      K_CALL:  begin npc_d = jabs; we_d = 1'b1; dst_d = RA; end
      K_BRU:   npc_d = bra;
      K_BCOND: npc_d = take ? bra : seq;
      K_RET:   npc_d = ra_val;
      K_JREG:  npc_d = opnd_a;
      K_CALLR: begin npc_d = opnd_a; we_d = 1'b1; dst_d = RA; end
      K_NXPC:  we_d = (dst != '0);
      default: npc_d = seq;
    endcase
  end
endmodule

// File: rtl/nxpc_unit.sv
module nxpc_unit #(
  parameter int XLEN    = 32,
  parameter int IMM_W   = 16,
  parameter int HI_KEEP = 4,
  parameter int REG_AW  = 5,
  parameter int RA_IDX  = 31,
  parameter logic [XLEN-1:0] RESET_PC = '0,
  localparam int JW     = XLEN - HI_KEEP - 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue,
  input  logic [XLEN-1:0]   pc,
  input  logic [3:0]        kind,
  input  logic [2:0]        cond,
  input  logic [IMM_W-1:0]  imm16,
  input  logic [JW-1:0]     imm26,
  input  logic [XLEN-1:0]   opnd_a,
  input  logic [XLEN-1:0]   opnd_b,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [REG_AW-1:0] dst,
  output logic [XLEN-1:0]   npc,
  output logic              link_we,
  output logic [REG_AW-1:0] link_dst,
  output logic [XLEN-1:0]   link_data
);
  // reset synchronizer: assert asynchronously, release on the clock
  logic [1:0] rst_pipe;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_core_n = rst_pipe[1];

  logic              take;
  logic [XLEN-1:0]   seq, jabs, bra, npc_d;
  logic              we_d;
  logic [REG_AW-1:0] dst_d;

  nxpc_cmp #(.XLEN(XLEN)) u_cmp (
    .a(opnd_a), .b(opnd_b), .sel(cond), .take(take)
  );

  nxpc_targets #(.XLEN(XLEN), .IMM_W(IMM_W), .HI_KEEP(HI_KEEP)) u_tgt (
    .pc(pc), .imm16(imm16), .imm26(imm26), .seq(seq), .jabs(jabs), .bra(bra)
  );

  nxpc_route #(.XLEN(XLEN), .REG_AW(REG_AW), .RA_IDX(RA_IDX)) u_route (
    .kind(kind), .take(take), .seq(seq), .jabs(jabs), .bra(bra),
    .opnd_a(opnd_a), .ra_val(ra_val), .dst(dst),
    .npc_d(npc_d), .we_d(we_d), .dst_d(dst_d)
  );

  // next-state for the write strobe: pulse only in issue cycles
  logic we_next;
  assign we_next = issue & we_d;

  always_ff @(posedge clk or negedge rst_core_n) begin
    if (!rst_core_n) begin
      npc       <= RESET_PC;
      link_we   <= 1'b0;
      link_dst  <= '0;
      link_data <= '0;
    end else begin
      link_we <= we_next;
      if (issue) begin
        npc       <= npc_d;
        link_dst  <= dst_d;
        link_data <= seq;
      end
    end
  end
endmodule

// File: rtl/nxpc_unit_chk.sv
module nxpc_unit_chk #(
  parameter int XLEN   = 32,
  parameter int REG_AW = 5
) (
  input logic              clk,
  input logic              rst_n,
  input logic              issue,
  input logic [XLEN-1:0]   pc,
  input logic [3:0]        kind,
  input logic [REG_AW-1:0] dst,
  input logic [XLEN-1:0]   npc,
  input logic              link_we,
  input logic [REG_AW-1:0] link_dst,
  input logic [XLEN-1:0]   link_data
);
  import nxpc_pkg::*;

  localparam logic [XLEN-1:0] STEP = XLEN'(4);

  logic lk_op;
  assign lk_op = (kind == K_CALL) || (kind == K_CALLR) ||
                 ((kind == K_NXPC) && (dst != '0));

  a_r2_seq_step: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (kind == K_SEQ) |=> (npc == $past(pc) + STEP) && !link_we);

  a_r3_keep_top: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (kind == K_JABS) |=> (npc[XLEN-1 -: 4] == $past(pc[XLEN-1 -: 4])) &&
                                  (npc[1:0] == 2'b00));

  a_r5_word_align: assert property (@(posedge clk) disable iff (!rst_n)
    issue && (kind == K_BRU) |=> (npc[1:0] == $past(pc[1:0])));

  a_r9_link_value: assert property (@(posedge clk) disable iff (!rst_n)
    issue && lk_op |=> link_we && (link_data == $past(pc) + STEP));

  a_r9_no_zero_dst: assert property (@(posedge clk) disable iff (!rst_n)
    link_we |-> (link_dst != '0));

  a_r10_no_link: assert property (@(posedge clk) disable iff (!rst_n)
    issue && !lk_op |=> !link_we);

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !issue |=> $stable(npc) && !link_we);
endmodule

bind nxpc_unit nxpc_unit_chk #(.XLEN(XLEN), .REG_AW(REG_AW)) u_chk (
  .clk(clk), .rst_n(rst_core_n), .issue(issue), .pc(pc), .kind(kind),
  .dst(dst), .npc(npc), .link_we(link_we), .link_dst(link_dst),
  .link_data(link_data)
);

// File: tb/nxpc_unit_test.sv
module nxpc_unit_test;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        issue;
  logic [31:0] pc, opnd_a, opnd_b, ra_val;
  logic [3:0]  kind;
  logic [2:0]  cond;
  logic [15:0] imm16;
  logic [25:0] imm26;
  logic [4:0]  dst;
  logic [31:0] npc, link_data;
  logic        link_we;
  logic [4:0]  link_dst;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  nxpc_unit uut (
    .clk(clk), .rst_n(rst_n), .issue(issue), .pc(pc), .kind(kind),
    .cond(cond), .imm16(imm16), .imm26(imm26), .opnd_a(opnd_a),
    .opnd_b(opnd_b), .ra_val(ra_val), .dst(dst), .npc(npc),
    .link_we(link_we), .link_dst(link_dst), .link_data(link_data)
  );

  function automatic bit m_take(input logic [2:0] c, input logic [31:0] a, input logic [31:0] b);
    case (c)
      3'd0: return $signed(a) >= $signed(b);
      3'd1: return $signed(a) <  $signed(b);
      3'd2: return a != b;
      3'd3: return a == b;
      3'd4: return a >= b;
      3'd5: return a <  b;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [31:0] m_npc();
    logic [31:0] s, j, br;
    s  = pc + 32'd4;
    j  = {pc[31:28], imm26, 2'b00};
    br = s + ({{16{imm16[15]}}, imm16} & 32'hFFFF_FFFC);
    case (kind)
      4'd1, 4'd2: return j;
      4'd3:       return br;
      4'd4:       return m_take(cond, opnd_a, opnd_b) ? br : s;
      4'd5:       return ra_val;
      4'd6, 4'd7: return opnd_a;
      default:    return s;
    endcase
  endfunction

  function automatic bit m_we();
    return (kind == 4'd2) || (kind == 4'd7) || ((kind == 4'd8) && (dst != 5'd0));
  endfunction

  function automatic logic [4:0] m_dst();
    return (kind == 4'd8) ? dst : 5'd31;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // issue the current fields and check after the capturing edge
  task automatic run_op(input string req);
    logic [31:0] en;
    logic [4:0] ed;
    logic [31:0] el;
    bit ew;
    en = m_npc(); ew = m_we(); ed = m_dst(); el = pc + 32'd4;
    issue = 1'b1;
    @(negedge clk);
    chk(req, "npc", npc, en);
    chk(req, "link_we", {31'd0, link_we}, {31'd0, ew});
    if (ew) begin
      chk(req, "link_dst", {27'd0, link_dst}, {27'd0, ed});
      chk(req, "link_data", link_data, el);
    end
    issue = 1'b0;
  endtask

  task automatic set_op(input logic [3:0] k, input logic [31:0] p);
    kind = k; pc = p;
  endtask

  initial begin
    #1_000_000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] held;
    void'($urandom(32'd2024));
    rst_n = 1'b0; issue = 1'b0; pc = 32'h0; kind = 4'd0; cond = 3'd0;
    imm16 = 16'h0; imm26 = 26'h0; opnd_a = 32'h0; opnd_b = 32'h0;
    ra_val = 32'h0; dst = 5'd0;
    repeat (3) @(negedge clk);
    chk("R1", "npc in reset", npc, 32'h0);
    chk("R1", "link_we in reset", {31'd0, link_we}, 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1", "npc after release", npc, 32'h0);

    // R2: wrap and undefined kind
    set_op(4'd0, 32'hFFFF_FFFC); run_op("R2");
    set_op(4'd13, 32'h0000_1000); run_op("R2");
    // R3: top bits kept
    set_op(4'd1, 32'hA123_4568); imm26 = 26'h3FF_FFFF; run_op("R3");
    // R4
    set_op(4'd2, 32'h5000_0010); imm26 = 26'h000_0123; run_op("R4");
    // R5: negative offset with low bits set
    set_op(4'd3, 32'h0000_0100); imm16 = 16'hFFF3; run_op("R5");
    set_op(4'd3, 32'h0000_0100); imm16 = 16'h7FFF; run_op("R5");
    // R6: signed vs unsigned split
    imm16 = 16'h0040;
    opnd_a = 32'h8000_0000; opnd_b = 32'h0000_0001;
    for (int c = 0; c < 8; c++) begin
      set_op(4'd4, 32'h0000_2000); cond = 3'(c); run_op("R6");
    end
    opnd_b = opnd_a;
    for (int c = 0; c < 8; c++) begin
      set_op(4'd4, 32'h0000_2000); cond = 3'(c); run_op("R6");
    end
    // R7
    ra_val = 32'h1234_5678; set_op(4'd5, 32'h40); run_op("R7");
    opnd_a = 32'hDEAD_BEE0; set_op(4'd6, 32'h40); run_op("R7");
    // R8: callr whose source holds the old return address
    ra_val = 32'h0000_0800; opnd_a = 32'h0000_0800;
    set_op(4'd7, 32'h0000_0900); run_op("R8");
    chk("R8", "jump uses old value", npc, 32'h0000_0800);
    // R9
    dst = 5'd7; set_op(4'd8, 32'h0000_0300); run_op("R9");
    dst = 5'd0; set_op(4'd8, 32'h0000_0300); run_op("R9");
    // R10
    set_op(4'd1, 32'h0); run_op("R10");
    // R11: idle cycle after a link write
    dst = 5'd3; set_op(4'd8, 32'h0000_0500); run_op("R9");
    held = npc;
    kind = 4'd1; imm26 = 26'h155_5555; pc = 32'hF000_0000;
    @(negedge clk);
    chk("R11", "npc held", npc, held);
    chk("R11", "link_we low", {31'd0, link_we}, 32'd0);

    // random mix
    for (int i = 0; i < 400; i++) begin
      pc = $urandom() & 32'hFFFF_FFFC;
      kind = 4'($urandom_range(0, 10));
      cond = 3'($urandom_range(0, 7));
      imm16 = 16'($urandom());
      imm26 = 26'($urandom());
      opnd_a = $urandom();
      opnd_b = ($urandom_range(0, 3) == 0) ? opnd_a : $urandom();
      ra_val = $urandom();
      dst = 5'($urandom());
      run_op("R2-mix R6-mix");
      if ($urandom_range(0, 7) == 0) begin
        held = npc;
        @(negedge clk);
        chk("R11", "random idle", npc, held);
      end
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule